// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the bus-side decoder of a synthesizable NAND flash device model with an 8-bit I/O port. Each write strobe carries one byte plus the active-low chip enable and the command-latch and address-latch pins. The block classifies the byte as a command, an address byte or a data byte. It keeps the current command and builds the column/row address from address bytes. It sends a one-cycle start pulse to a separate array controller whenever an operation is fully specified. Data bytes are left to that controller.

The block also holds the status byte and the read-ID byte sequence, and drives them on its output port when a read strobe consumes them. A parameter selects small-page (512-byte page, 8-bit column, three address bytes) or large-page (2048-byte page, 16-bit column, four address bytes) behaviour.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is a command only when `wr_stb`=1, `ce_n`=0 and `cle`=1. It is an address byte when `wr_stb`=1, `ce_n`=0, `ale`=1 and `cle`=0. A byte strobed while `ce_n`=1 has no effect.
- R2: Each address byte is stored at byte lane N of a 32-bit address register, where N is the number of address bytes received so far (lane 0 is the least significant), and the count then increments. `col_addr` is the low 8 bits of the register (small-page) or the low 16 bits (large-page), zero-extended. `row_addr` is the rest of the register.
- R3: Code 0x00 selects read with `col_offset`=0. Code 0x01 selects read with `col_offset`=0x100. Code 0x50 selects read with `col_offset` equal to the page size (0x200 small, 0x800 large). After any of the three, `cur_cmd` reads 0x00.
- R4: With read (0x00) current, the address byte that brings the count to 3 (small) or 4 (large) raises `go_read` for one cycle. With 0x80 current, the same byte raises `go_load`.
- R5: With 0x90 current, the first address byte raises `go_id`. Read strobes then yield the manufacturer ID, the device ID, a fill byte, and then 0xC0 (small) or 0x15 (large), followed by 0x00. Any accepted command byte other than 0x70 discards bytes not yet read.
- R6: These codes act on the command byte itself: 0x10 raises `go_prog`, 0xD0 raises `go_erase`, 0x70 raises `go_status`, and 0xFF raises `go_reset`. In large-page mode 0x35 and 0xE0 raise `go_read`. Code 0xD0 also shifts the address register left by the column width, so that the row bytes land in the row field.
- R7: Every accepted command byte except 0xE0 clears the address-byte count.
- R8: In large-page mode, 0x30 arriving while read is current has no effect. Code 0x05 clears the column field and the address count and leaves `cur_cmd` unchanged.
- R9: Reset (0xFF, or `rst_n` low) sets `cur_cmd` to 0x00 and clears the address register, the count, `col_offset` and pending output. It also clears every status bit except bit 7.
- R10: After 0x70, the output byte is the status: bit 7 = `wp_n` (1 = unprotected), bit 6 = `busy_in`, bit 0 = sticky error from `err_in`, and the other bits are 0. The fields follow their inputs one cycle later. One read strobe consumes the status byte.
- R11: Codes outside the set in R3 to R8 are ignored and leave all state unchanged. This includes 0x05 and 0x30 in small-page mode.
- R12: An `err_in` pulse in the same cycle as a reset command sets the error bit. A read strobe in the same cycle as a command byte that loads output is dropped, so the new byte stays pending.
- R13: The seven start pulses are encoded as {reset, status, id, erase, prog, load, read}. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe: sample pins and `din` this cycle |
| rd_stb | input | 1 | Read strobe: consume the current output byte |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| din | input | 8 | Byte written by the host |
| wp_n | input | 1 | Write protect, active low |
| busy_in | input | 1 | Busy flag from the array controller |
| err_in | input | 1 | Error pulse from the array controller |
| dout | output | 8 | Status or ID byte, 0 when nothing is pending |
| go_read | output | 1 | Start page read |
| go_load | output | 1 | Program setup complete, start buffer load |
| go_prog | output | 1 | Start page program |
| go_erase | output | 1 | Start block erase |
| go_id | output | 1 | Read-ID issued |
| go_status | output | 1 | Status read issued |
| go_reset | output | 1 | Device reset issued |
| col_addr | output | 16 | Column field of the address register |
| row_addr | output | 24 | Row field of the address register |
| col_offset | output | 12 | Column offset chosen by the read alias |
| cur_cmd | output | 8 | Current command code |

## Verification
Two functions can fall in the same cycle. The first pair is the reset command, which clears status, and an error report from the array controller. The second pair is a host read strobe that consumes output and a status command that reloads it. The bench drives each pair on the same clock edge. An error pulse coinciding with 0xFF must still show as status bit 0 on the next status read. A read strobe coinciding with 0x70 must leave the new status byte pending until a separate read strobe consumes it. Two instances, one in each page mode, receive the same byte stream, and a scoreboard checks every start pulse against its own mode's expectation.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
   localparam logic [7:0] OP_READ       = 8'h00;
   localparam logic [7:0] OP_READ_HI    = 8'h01;
   localparam logic [7:0] OP_READ_SPARE = 8'h50;
   localparam logic [7:0] OP_READ_CONF  = 8'h30;
   localparam logic [7:0] OP_COL_SETUP  = 8'h05;
   localparam logic [7:0] OP_COL_GO     = 8'hE0;
   localparam logic [7:0] OP_READ_NSER  = 8'h35;
   localparam logic [7:0] OP_IDENT      = 8'h90;
   localparam logic [7:0] OP_RESET      = 8'hFF;
   localparam logic [7:0] OP_PROG_SETUP = 8'h80;
   localparam logic [7:0] OP_PROG_GO    = 8'h10;
   localparam logic [7:0] OP_ERASE_SET  = 8'h60;
   localparam logic [7:0] OP_ERASE_GO   = 8'hD0;
   localparam logic [7:0] OP_STATUS     = 8'h70;

   localparam int LANES      = 4;
   localparam int ADDR_W     = 8 * LANES;
   localparam int CNT_W      = 3;
   localparam int OFF_W      = 12;
   localparam int COL_PORT_W = 16;
   localparam int ROW_PORT_W = 24;

   typedef struct packed {
      logic rst;
      logic stat;
      logic id;
      logic erase;
      logic prog;
      logic load;
      logic read;
   } go_t;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_ID   = 2'd1,
      SRC_STAT = 2'd2
   } src_e;
endpackage

// File: rtl/nand_byte_class.sv
module nand_byte_class
   import nand_cmd_pkg::*;
#(
   parameter int LARGE_PAGE = 0,
   parameter int PAGE_BYTES = 512
) (
   input  logic             wr_stb,
   input  logic             ce_n,
   input  logic             cle,
   input  logic             ale,
   input  logic [7:0]       din,
   input  logic [7:0]       cur_cmd,
   output logic             cmd_take,
   output logic [7:0]       cmd_val,
   output logic             off_load,
   output logic [OFF_W-1:0] off_val,
   output logic             cnt_clr,
   output logic             col_clr,
   output logic             addr_take
);
   localparam bit LP = (LARGE_PAGE != 0);

   logic is_cmd;

   assign is_cmd    = wr_stb && !ce_n && cle;
   assign addr_take = wr_stb && !ce_n && ale && !cle;

   always_comb begin
      cmd_take = 1'b0;
      cmd_val  = din;
      off_load = 1'b0;
      off_val  = '0;
      col_clr  = 1'b0;
      if (is_cmd) begin
         if (LP && cur_cmd == OP_READ && din == OP_READ_CONF) begin
            cmd_take = 1'b0;
         end else if (LP && din == OP_COL_SETUP) begin
            col_clr = 1'b1;
         end else begin
            unique case (din)
               OP_READ: begin
                  cmd_take = 1'b1;
                  off_load = 1'b1;
               end
               OP_READ_HI: begin
                  cmd_take = 1'b1;
                  cmd_val  = OP_READ;
                  off_load = 1'b1;
                  off_val  = OFF_W'(12'h100);
               end
               OP_READ_SPARE: begin
                  cmd_take = 1'b1;
                  cmd_val  = OP_READ;
                  off_load = 1'b1;
                  off_val  = OFF_W'(PAGE_BYTES);
               end
               OP_IDENT, OP_PROG_SETUP, OP_PROG_GO, OP_ERASE_SET,
               OP_ERASE_GO, OP_STATUS, OP_READ_NSER, OP_COL_GO,
               OP_RESET:
                  cmd_take = 1'b1;
               default:
                  cmd_take = 1'b0;
            endcase
         end
      end
   end

   assign cnt_clr = (cmd_take && din != OP_COL_GO) || col_clr;
endmodule

// File: rtl/nand_addr_acc.sv
module nand_addr_acc
   import nand_cmd_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_take,
   input  logic [7:0]       din,
   input  logic             cnt_clr,
   input  logic             col_clr,
   input  logic             shift_row,
   input  logic             clr_all,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q
);
   localparam int COL_BYTES = COL_W / 8;
   localparam logic [CNT_W-1:0] CNT_SAT = '1;

   logic [ADDR_W-1:0] shifted;
   assign shifted = addr_q << COL_W;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      localparam bit IN_COL = (b < COL_BYTES);
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (clr_all)
            byte_q <= '0;
         else if (shift_row)
            byte_q <= shifted[8*b +: 8];
         else if (col_clr && IN_COL)
            byte_q <= '0;
         else if (addr_take && cnt_q == CNT_W'(b))
            byte_q <= din;
      end
      assign addr_q[8*b +: 8] = byte_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_all || cnt_clr)
         cnt_q <= '0;
      else if (addr_take && cnt_q != CNT_SAT)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_cmd_pkg::*;
#(
   parameter int LARGE_PAGE = 0,
   parameter int ADDR_BYTES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_take,
   input  logic [7:0]       cmd_val,
   input  logic             off_load,
   input  logic [OFF_W-1:0] off_val,
   input  logic             addr_take,
   input  logic [CNT_W-1:0] cnt_q,
   output go_t              go_next,
   output go_t              go_q,
   output logic [7:0]       cmd_q,
   output logic [OFF_W-1:0] off_q
);
   localparam bit LP = (LARGE_PAGE != 0);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

   always_comb begin
      go_next = '0;
      if (cmd_take) begin
         unique case (cmd_val)
            OP_PROG_GO:   go_next.prog  = 1'b1;
            OP_ERASE_GO:  go_next.erase = 1'b1;
            OP_STATUS:    go_next.stat  = 1'b1;
            OP_RESET:     go_next.rst   = 1'b1;
            OP_READ_NSER,
            OP_COL_GO:    go_next.read  = LP;
            default:      go_next       = '0;
         endcase
      end else if (addr_take) begin
         if (cmd_q == OP_IDENT && cnt_q == '0)
            go_next.id = 1'b1;
         if (cnt_q == LAST && cmd_q == OP_READ)
            go_next.read = 1'b1;
         if (cnt_q == LAST && cmd_q == OP_PROG_SETUP)
            go_next.load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= OP_READ;
         off_q <= '0;
         go_q  <= '0;
      end else begin
         go_q <= go_next;
         if (go_next.rst) begin
            cmd_q <= OP_READ;
            off_q <= '0;
         end else begin
            if (cmd_take)
               cmd_q <= cmd_val;
            if (off_load)
               off_q <= off_val;
         end
      end
   end
endmodule

// File: rtl/nand_out_unit.sv
module nand_out_unit
   import nand_cmd_pkg::*;
#(
   parameter int         LARGE_PAGE = 0,
   parameter logic [7:0] MFR_ID     = 8'hEC,
   parameter logic [7:0] DEV_ID     = 8'h73,
   parameter logic [7:0] FILL_BYTE  = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_id,
   input  logic       ld_stat,
   input  logic       clr,
   input  logic       drop,
   input  logic       rd_stb,
   input  logic       wp_n,
   input  logic       busy_in,
   input  logic       err_in,
   output logic [7:0] status,
   output logic [7:0] dout
);
   localparam int   ID_LEN = 4;
   localparam int   LEN_W  = $clog2(ID_LEN + 1);

   src_e             src_q;
   logic [1:0]       idx_q;
   logic [LEN_W-1:0] len_q;
   logic             wp_q, busy_q, err_q;
   logic [7:0]       id_last;
   logic [7:0]       id_byte;

   if (LARGE_PAGE != 0) begin : g_id_lp
      assign id_last = 8'h15;
   end else begin : g_id_sp
      assign id_last = 8'hC0;
   end

   always_comb begin
      unique case (idx_q)
         2'd0:    id_byte = MFR_ID;
         2'd1:    id_byte = DEV_ID;
         2'd2:    id_byte = FILL_BYTE;
         default: id_byte = id_last;
      endcase
   end

   assign status = {wp_q, busy_q, 5'b0, err_q};

   always_comb begin
      if (len_q == '0)
         dout = 8'h00;
      else if (src_q == SRC_STAT)
         dout = status;
      else if (src_q == SRC_ID)
         dout = id_byte;
      else
         dout = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_NONE;
         idx_q <= '0;
         len_q <= '0;
      end else if (clr || drop) begin
         src_q <= SRC_NONE;
         idx_q <= '0;
         len_q <= '0;
      end else if (ld_id) begin
         src_q <= SRC_ID;
         idx_q <= '0;
         len_q <= LEN_W'(ID_LEN);
      end else if (ld_stat) begin
         src_q <= SRC_STAT;
         idx_q <= '0;
         len_q <= LEN_W'(1);
      end else if (rd_stb && len_q != '0) begin
         idx_q <= idx_q + 1'b1;
         len_q <= len_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q   <= 1'b0;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         wp_q   <= wp_n;
         busy_q <= busy_in && !clr;
         err_q  <= (err_q && !clr) || err_in;
      end
   end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
   import nand_cmd_pkg::*;
#(
   parameter int         LARGE_PAGE = 0,
   parameter logic [7:0] MFR_ID     = 8'hEC,
   parameter logic [7:0] DEV_ID     = 8'h73,
   parameter logic [7:0] FILL_BYTE  = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic        rd_stb,
   input  logic        ce_n,
   input  logic        cle,
   input  logic        ale,
   input  logic [7:0]  din,
   input  logic        wp_n,
   input  logic        busy_in,
   input  logic        err_in,
   output logic [7:0]  dout,
   output logic        go_read,
   output logic        go_load,
   output logic        go_prog,
   output logic        go_erase,
   output logic        go_id,
   output logic        go_status,
   output logic        go_reset,
   output logic [15:0] col_addr,
   output logic [23:0] row_addr,
   output logic [11:0] col_offset,
   output logic [7:0]  cur_cmd
);
   localparam bit LP         = (LARGE_PAGE != 0);
   localparam int PAGE_BYTES = LP ? 2048 : 512;
   localparam int COL_W      = LP ? 16 : 8;
   localparam int ADDR_BYTES = LP ? 4 : 3;
   localparam int ROW_W      = ADDR_W - COL_W;

   if (LARGE_PAGE != 0 && LARGE_PAGE != 1) begin : g_bad_mode
      $error("LARGE_PAGE must be 0 or 1");
   end
   if (PAGE_BYTES >= (1 << OFF_W)) begin : g_bad_off
      $error("column offset field too narrow for page size");
   end
   if (ADDR_BYTES > LANES || COL_W > COL_PORT_W || ROW_W > ROW_PORT_W) begin : g_bad_addr
      $error("address register lanes do not fit the port widths");
   end

   logic             cmd_take, off_load, cnt_clr, col_clr, addr_take;
   logic [7:0]       cmd_val;
   logic [OFF_W-1:0] off_val, off_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       cmd_q;
   logic [7:0]       status_w;
   go_t              go_next, go_q;

   nand_byte_class #(
      .LARGE_PAGE (LARGE_PAGE),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_class (
      .wr_stb    (wr_stb),
      .ce_n      (ce_n),
      .cle       (cle),
      .ale       (ale),
      .din       (din),
      .cur_cmd   (cmd_q),
      .cmd_take  (cmd_take),
      .cmd_val   (cmd_val),
      .off_load  (off_load),
      .off_val   (off_val),
      .cnt_clr   (cnt_clr),
      .col_clr   (col_clr),
      .addr_take (addr_take)
   );

   nand_addr_acc #(
      .COL_W (COL_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_take (addr_take),
      .din       (din),
      .cnt_clr   (cnt_clr),
      .col_clr   (col_clr),
      .shift_row (go_next.erase),
      .clr_all   (go_next.rst),
      .addr_q    (addr_q),
      .cnt_q     (cnt_q)
   );

   nand_cmd_seq #(
      .LARGE_PAGE (LARGE_PAGE),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_take  (cmd_take),
      .cmd_val   (cmd_val),
      .off_load  (off_load),
      .off_val   (off_val),
      .addr_take (addr_take),
      .cnt_q     (cnt_q),
      .go_next   (go_next),
      .go_q      (go_q),
      .cmd_q     (cmd_q),
      .off_q     (off_q)
   );

   nand_out_unit #(
      .LARGE_PAGE (LARGE_PAGE),
      .MFR_ID     (MFR_ID),
      .DEV_ID     (DEV_ID),
      .FILL_BYTE  (FILL_BYTE)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_id   (go_next.id),
      .ld_stat (go_next.stat),
      .clr     (go_next.rst),
      .drop    (cmd_take && cmd_val != OP_STATUS),
      .rd_stb  (rd_stb),
      .wp_n    (wp_n),
      .busy_in (busy_in),
      .err_in  (err_in),
      .status  (status_w),
      .dout    (dout)
   );

   assign go_read    = go_q.read;
   assign go_load    = go_q.load;
   assign go_prog    = go_q.prog;
   assign go_erase   = go_q.erase;
   assign go_id      = go_q.id;
   assign go_status  = go_q.stat;
   assign go_reset   = go_q.rst;
   assign col_addr   = COL_PORT_W'(addr_q[COL_W-1:0]);
   assign row_addr   = ROW_PORT_W'(addr_q[ADDR_W-1:COL_W]);
   assign col_offset = off_q;
   assign cur_cmd    = cmd_q;
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_stb,
   input logic        ce_n,
   input logic        ale,
   input logic        wp_n,
   input logic [6:0]  go,
   input logic [7:0]  status,
   input logic [15:0] col_addr,
   input logic [23:0] row_addr,
   input logic [11:0] col_offset
);
   // R13
   pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(go));

   // R1
   pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go != 7'd0) |-> $past(wr_stb && !ce_n));

   // R5
   id_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go[4] |-> $past(ale));

   // R9
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go[6] |-> (col_addr == 16'd0 && row_addr == 24'd0 && col_offset == 12'd0));

   // R10
   wp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (status[7] == $past(wp_n)));
endmodule

bind nand_cmd_front nand_cmd_front_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .ce_n       (ce_n),
   .ale        (ale),
   .wp_n       (wp_n),
   .go         ({go_reset, go_status, go_id, go_erase, go_prog, go_load, go_read}),
   .status     (status_w),
   .col_addr   (col_addr),
   .row_addr   (row_addr),
   .col_offset (col_offset)
);

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, wr_stb, rd_stb, ce_n, cle, ale, wp_n, busy_in, err_in;
   logic [7:0] din;

   logic [7:0]  s_dout, l_dout, s_cmd, l_cmd;
   logic [15:0] s_col, l_col;
   logic [23:0] s_row, l_row;
   logic [11:0] s_off, l_off;
   logic [6:0]  s_go, l_go;

   int checks = 0;
   int errors = 0;
   logic [6:0] q_s[$], q_l[$];
   string      t_s[$], t_l[$];

   localparam logic [6:0] GR = 7'h01, GL = 7'h02, GP = 7'h04, GE = 7'h08,
                          GI = 7'h10, GS = 7'h20, GX = 7'h40;

   nand_cmd_front #(.LARGE_PAGE(0), .MFR_ID(8'hEC), .DEV_ID(8'h73), .FILL_BYTE(8'hA5)) uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .ce_n(ce_n),
      .cle(cle), .ale(ale), .din(din), .wp_n(wp_n), .busy_in(busy_in), .err_in(err_in),
      .dout(s_dout), .go_read(s_go[0]), .go_load(s_go[1]), .go_prog(s_go[2]),
      .go_erase(s_go[3]), .go_id(s_go[4]), .go_status(s_go[5]), .go_reset(s_go[6]),
      .col_addr(s_col), .row_addr(s_row), .col_offset(s_off), .cur_cmd(s_cmd));

   nand_cmd_front #(.LARGE_PAGE(1), .MFR_ID(8'hEC), .DEV_ID(8'h73), .FILL_BYTE(8'hA5)) uut_lp (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .ce_n(ce_n),
      .cle(cle), .ale(ale), .din(din), .wp_n(wp_n), .busy_in(busy_in), .err_in(err_in),
      .dout(l_dout), .go_read(l_go[0]), .go_load(l_go[1]), .go_prog(l_go[2]),
      .go_erase(l_go[3]), .go_id(l_go[4]), .go_status(l_go[5]), .go_reset(l_go[6]),
      .col_addr(l_col), .row_addr(l_row), .col_offset(l_off), .cur_cmd(l_cmd));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // scoreboard monitors: every pulse must match the head of its queue
   always @(negedge clk) begin
      if (rst_n === 1'b1 && s_go != 7'd0) begin
         if (q_s.size() == 0) chk("R13 small unexpected pulse", 32'(s_go), 32'd0);
         else chk({t_s.pop_front(), " small pulse"}, 32'(s_go), 32'(q_s.pop_front()));
      end
      if (rst_n === 1'b1 && l_go != 7'd0) begin
         if (q_l.size() == 0) chk("R13 large unexpected pulse", 32'(l_go), 32'd0);
         else chk({t_l.pop_front(), " large pulse"}, 32'(l_go), 32'(q_l.pop_front()));
      end
   end

   task automatic expect_go(input logic [6:0] es, input logic [6:0] el, input string tag);
      if (es != 7'd0) begin q_s.push_back(es); t_s.push_back(tag); end
      if (el != 7'd0) begin q_l.push_back(el); t_l.push_back(tag); end
   endtask

   task automatic wr(input logic c_n, input logic c, input logic a, input logic [7:0] d,
                     input logic [6:0] es, input logic [6:0] el, input string tag);
      expect_go(es, el, tag);
      @(negedge clk);
      ce_n = c_n; cle = c; ale = a; din = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] d, input logic [6:0] es, input logic [6:0] el, input string tag);
      wr(1'b0, 1'b1, 1'b0, d, es, el, tag);
   endtask

   task automatic adr(input logic [7:0] d, input logic [6:0] es, input logic [6:0] el, input string tag);
      wr(1'b0, 1'b0, 1'b1, d, es, el, tag);
   endtask

   task automatic rd();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; ce_n = 1'b0; cle = 1'b0; ale = 1'b0;
      din = 8'h00; wp_n = 1'b1; busy_in = 1'b0; err_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 reset cur_cmd", {s_cmd, l_cmd}, 16'h0000);
      chk("R9 reset address", {s_col, s_row, l_col, l_row}, '0);
      chk("R9 reset dout", {s_dout, l_dout}, 16'h0000);

      // R10 status byte follows pins
      cmd(8'h70, GS, GS, "R6");
      chk("R10 status unprotected", {s_dout, l_dout}, 16'h8080);
      wp_n = 1'b0; @(negedge clk);
      chk("R10 status protected", {s_dout, l_dout}, 16'h0000);
      busy_in = 1'b1; @(negedge clk);
      chk("R10 status busy", {s_dout, l_dout}, 16'h4040);
      busy_in = 1'b0; wp_n = 1'b1; @(negedge clk);
      rd();
      chk("R10 status consumed", {s_dout, l_dout}, 16'h0000);

      // R5 read-ID sequence
      cmd(8'h90, 7'd0, 7'd0, "R5");
      adr(8'h00, GI, GI, "R5");
      chk("R5 id byte0", {s_dout, l_dout}, 16'hECEC); rd();
      chk("R5 id byte1", {s_dout, l_dout}, 16'h7373); rd();
      chk("R5 id byte2", {s_dout, l_dout}, 16'hA5A5); rd();
      chk("R5 id byte3", {s_dout, l_dout}, 16'hC015); rd();
      chk("R5 id exhausted", {s_dout, l_dout}, 16'h0000);
      cmd(8'h90, 7'd0, 7'd0, "R5");
      adr(8'h00, GI, GI, "R5");
      rd();
      cmd(8'h00, 7'd0, 7'd0, "R5");
      chk("R5 leftover id dropped", {s_dout, l_dout}, 16'h0000);

      // R2 R4 address assembly and read completion
      adr(8'h12, 7'd0, 7'd0, "R4");
      adr(8'h34, 7'd0, 7'd0, "R4");
      adr(8'h56, GR, 7'd0, "R4");
      adr(8'h78, 7'd0, GR, "R4");
      chk("R2 small col/row", {s_col, s_row}, {16'h0012, 24'h785634});
      chk("R2 large col/row", {l_col, l_row}, {16'h3412, 24'h007856});
      // R8 confirm code ignored in large mode, R11 unknown in small
      cmd(8'h30, 7'd0, 7'd0, "R8");
      chk("R8 R11 0x30 leaves read", {s_cmd, l_cmd}, 16'h0000);

      // R3 read aliases
      cmd(8'h01, 7'd0, 7'd0, "R3");
      chk("R3 offset 0x100", {s_off, l_off, s_cmd, l_cmd}, {12'h100, 12'h100, 16'h0000});
      cmd(8'h50, 7'd0, 7'd0, "R3");
      chk("R3 offset spare", {s_off, l_off, s_cmd, l_cmd}, {12'h200, 12'h800, 16'h0000});
      cmd(8'h00, 7'd0, 7'd0, "R3");
      chk("R3 offset zero", {s_off, l_off}, 24'h0);

      // R7 count cleared by a command byte
      adr(8'hAA, 7'd0, 7'd0, "R7");
      adr(8'hBB, 7'd0, 7'd0, "R7");
      cmd(8'h00, 7'd0, 7'd0, "R7");
      adr(8'h01, 7'd0, 7'd0, "R7");
      adr(8'h02, 7'd0, 7'd0, "R7");
      adr(8'h03, GR, 7'd0, "R7");
      adr(8'h04, 7'd0, GR, "R7");
      chk("R7 small col/row", {s_col, s_row}, {16'h0001, 24'h040302});
      chk("R7 large col/row", {l_col, l_row}, {16'h0201, 24'h000403});

      // R8 column-only re-address, R7 count kept over 0xE0
      cmd(8'h05, 7'd0, 7'd0, "R8");
      chk("R8 0x05 keeps command", {s_cmd, l_cmd}, 16'h0000);
      chk("R8 0x05 clears column", l_col, 16'h0000);
      adr(8'h44, 7'd0, 7'd0, "R8");
      adr(8'h08, 7'd0, 7'd0, "R8");
      cmd(8'hE0, 7'd0, GR, "R6");
      chk("R6 cur_cmd E0", {s_cmd, l_cmd}, 16'hE0E0);
      adr(8'h99, 7'd0, 7'd0, "R7");
      chk("R7 count kept over E0 large", {l_col, l_row}, {16'h0844, 24'h000499});
      chk("R11 small ignores 0x05", {s_col, s_row}, {16'h0001, 24'h040302});
      cmd(8'h35, 7'd0, GR, "R6");

      // R4 program setup, data bytes, program start
      cmd(8'h80, 7'd0, 7'd0, "R4");
      adr(8'h00, 7'd0, 7'd0, "R4");
      adr(8'h01, 7'd0, 7'd0, "R4");
      adr(8'h02, GL, 7'd0, "R4");
      adr(8'h03, 7'd0, GL, "R4");
      wr(1'b0, 1'b0, 1'b0, 8'h5A, 7'd0, 7'd0, "R1");
      wr(1'b0, 1'b0, 1'b0, 8'hA5, 7'd0, 7'd0, "R1");
      cmd(8'h10, GP, GP, "R6");

      // R6 erase with row shift
      cmd(8'h60, 7'd0, 7'd0, "R6");
      adr(8'h21, 7'd0, 7'd0, "R6");
      adr(8'h43, 7'd0, 7'd0, "R6");
      adr(8'h65, 7'd0, 7'd0, "R6");
      cmd(8'hD0, GE, GE, "R6");
      chk("R6 small erase row", {s_col, s_row}, {16'h0000, 24'h654321});
      chk("R6 large erase row", {l_col, l_row}, {16'h0000, 24'h004321});

      // R1 deselected strobe, R11 unknown code
      wr(1'b1, 1'b1, 1'b0, 8'hFF, 7'd0, 7'd0, "R1");
      chk("R1 deselected byte ignored", {s_cmd, l_cmd, s_row}, {16'hD0D0, 24'h654321});
      cmd(8'h33, 7'd0, 7'd0, "R11");
      chk("R11 unknown code ignored", {s_cmd, l_cmd}, 16'hD0D0);

      // R12 error pulse in the reset cycle
      expect_go(GX, GX, "R12");
      @(negedge clk);
      ce_n = 1'b0; cle = 1'b1; din = 8'hFF; wr_stb = 1'b1; err_in = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cle = 1'b0; err_in = 1'b0;
      chk("R9 reset command state", {s_cmd, l_cmd, s_off, l_off}, '0);
      chk("R9 reset command address", {s_col, s_row, l_col, l_row}, '0);
      cmd(8'h70, GS, GS, "R12");
      chk("R12 error kept over reset", {s_dout, l_dout}, 16'h8181);

      // R12 read strobe coinciding with a status reload
      expect_go(GS, GS, "R12");
      @(negedge clk);
      cle = 1'b1; din = 8'h70; wr_stb = 1'b1; rd_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cle = 1'b0; rd_stb = 1'b0;
      chk("R12 status still pending", {s_dout, l_dout}, 16'h8181);
      rd();
      chk("R10 status consumed after reload", {s_dout, l_dout}, 16'h0000);

      repeat (3) @(negedge clk);
      chk("R13 small pulses all seen", q_s.size(), 0);
      chk("R13 large pulses all seen", q_l.size(), 0);
      finish_run();
   end
endmodule